// File: doc/BRIEF.md
# Serial EEPROM Slave Command Front End

This block is the serial-bus slave side of a byte-wide nonvolatile memory. It watches an active-low chip select, a serial clock and a serial data input, collects an 8-bit opcode followed by address and data bytes, and decodes six commands: array read, array write, write-enable, write-disable, status read and status write. Array accesses go out on a simple synchronous memory port with one cycle of read latency. Status writes go to an external protection unit, which returns its status byte for status reads. Read data and status bytes are shifted back out on the serial data output.

All serial inputs are brought into the system clock domain through two-flop synchronizers. The block works out the serial clock edges from the synchronized copy, so SPI mode 0 and mode 3 both work without configuration. A committed array write or status write starts an internal self-timed write cycle of `WR_CYCLES` system clocks. During that cycle only the status read is honoured, and it returns all ones.

Top module: `spi_ee_front`

## Requirements
- R1: After reset, `so_oe_o`, `busy_o`, `mem_req_o`, `mem_we_o` and `stat_wr_o` are all low.
- R2: Opcode, address and data are taken most significant bit first. The address field is 16 bits wide, and only its low 10 bits select a location, so the upper 6 bits have no effect.
- R3: Opcode 0x03 followed by two address bytes returns the byte at that address MSB first. Each further byte comes from the next address, and the address wraps from 0x3FF to 0x000.
- R4: Opcode 0x02 with the write latch set performs one array write of the first data byte to the given address, issued as a single `mem_we_o` pulse when CS rises on a byte boundary. Later data bytes are discarded. The write starts the busy cycle and clears the write latch. With the latch clear, no write occurs.
- R5: Opcode 0x06 sets the write latch and opcode 0x04 clears it. The latch is visible as status bit 1.
- R6: Opcode 0x05 returns the status byte {`stat_i[7:2]`, write latch, 0} MSB first, repeated for every further byte.
- R7: Opcode 0x01 with the write latch set pulses `stat_wr_o` once, with the first data byte on `stat_wdata_o`, when CS rises on a byte boundary. It then starts the busy cycle and clears the latch.
- R8: While `busy_o` is high, every opcode except 0x05 is ignored (including 0x06), and a status read returns 0xFF.
- R9: If CS rises partway through a byte, the command is dropped: no array write, no status write, no busy cycle.
- R10: `so_oe_o` is high only while a read or status byte is being shifted out, and it is low whenever CS is high.
- R11: The same commands give the same results in SPI mode 0 (clock idles low) and SPI mode 3 (clock idles high).
- R12: An undefined opcode has no effect, and SO stays disabled for the rest of that selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO (high-impedance when low) |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write qualifier for mem_req_o |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after a read strobe |
| stat_wr_o | output | 1 | Status write strobe to the protection unit |
| stat_wdata_o | output | 8 | Status write data |
| stat_i | input | 8 | Status byte from the protection unit |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume the host keeps each serial clock phase at least four system clocks long. They also assume it holds SI stable across the rising serial clock edge and keeps CS edges at least a few system clocks away from any serial clock edge. Under those conditions every edge is seen exactly once after synchronization, and a read fetch lands before the next shifting edge. The stimulus uses an 8-cycle half period for the serial clock and 4-cycle guard intervals around CS in both clock modes. It never drives a serial clock edge in the same cycle as a CS edge, so the edge-dependent properties such as the single write pulse and the quiet busy window stay inside those assumptions.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } opcode_e;

  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA, PH_DEAD} phase_e;
  typedef enum logic [1:0] {C_RD, C_WR, C_RDSR, C_WRSR} cmd_e;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= RST_VAL;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/spi_ee_txsh.sv
module spi_ee_txsh #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= '0;
    else if (load_i) tx_q <= data_i;
    else if (shift_i) tx_q <= {tx_q[W-2:0], 1'b0};
  end

  assign bit_o = tx_q[W-1];
endmodule

// File: rtl/spi_ee_front.sv
module spi_ee_front
  import spi_ee_pkg::*;
#(
  parameter int AW           = 10,
  parameter int ADDR_FIELD_W = 16,
  parameter int WR_CYCLES    = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              stat_wr_o,
  output logic [BYTE_W-1:0] stat_wdata_o,
  input  logic [BYTE_W-1:0] stat_i,
  output logic              busy_o
);
  localparam int ADDR_BYTES = ADDR_FIELD_W / BYTE_W;
  localparam int ABW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int BCW        = $clog2(BYTE_W);

  // synchronized serial inputs
  logic cs_s, sck_s, si_s;
  logic cs_d_q, sck_d_q;

  spi_ee_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, si_i}),
    .q_o    ({cs_s, sck_s, si_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      cs_d_q  <= cs_s;
      sck_d_q <= sck_s;
    end
  end

  logic cs_act, cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_act   = ~cs_s;
  assign cs_fall  = ~cs_s & cs_d_q;
  assign cs_rise  = cs_s & ~cs_d_q;
  assign sck_rise = cs_act & sck_s & ~sck_d_q;
  assign sck_fall = cs_act & ~sck_s & sck_d_q;

  // command state
  phase_e            phase_q;
  cmd_e              cmd_q;
  logic [BCW-1:0]    bit_q;
  logic [ABW-1:0]    abyte_q;
  logic [BYTE_W-1:0] rx_q, wdata_q;
  logic [AW-1:0]     addr_q;
  logic              wel_q, pend_q, tx_act_q, fetch_q, rd_vld_q;

  logic [BYTE_W-1:0] rx_next, stat_now;
  logic              byte_done, commit, timer_busy;

  assign rx_next   = {rx_q[BYTE_W-2:0], si_s};
  assign byte_done = sck_rise && (bit_q == BCW'(BYTE_W - 1));
  assign stat_now  = timer_busy ? '1 : {stat_i[BYTE_W-1:2], wel_q, 1'b0};
  assign commit    = cs_rise && pend_q && (bit_q == '0) && (phase_q == PH_DATA) && !timer_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_DEAD;
      cmd_q    <= C_RD;
      bit_q    <= '0;
      abyte_q  <= '0;
      rx_q     <= '0;
      wdata_q  <= '0;
      addr_q   <= '0;
      wel_q    <= 1'b0;
      pend_q   <= 1'b0;
      tx_act_q <= 1'b0;
      fetch_q  <= 1'b0;
      rd_vld_q <= 1'b0;
    end else if (cs_fall) begin
      phase_q  <= PH_OP;
      bit_q    <= '0;
      abyte_q  <= '0;
      pend_q   <= 1'b0;
      tx_act_q <= 1'b0;
      fetch_q  <= 1'b0;
      rd_vld_q <= 1'b0;
    end else if (cs_rise) begin
      phase_q  <= PH_DEAD;
      pend_q   <= 1'b0;
      tx_act_q <= 1'b0;
      fetch_q  <= 1'b0;
      rd_vld_q <= 1'b0;
      if (commit) wel_q <= 1'b0;
    end else begin
      fetch_q  <= 1'b0;
      rd_vld_q <= fetch_q;
      if (rd_vld_q) tx_act_q <= 1'b1;
      if (sck_rise) begin
        bit_q <= bit_q + 1'b1;
        rx_q  <= rx_next;
        if (phase_q == PH_ADDR) addr_q <= {addr_q[AW-2:0], si_s};
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_OP: begin
            phase_q <= PH_DEAD;
            if (timer_busy) begin
              if (rx_next == OP_RDSR) begin
                phase_q  <= PH_DATA;
                cmd_q    <= C_RDSR;
                tx_act_q <= 1'b1;
              end
            end else begin
              case (rx_next)
                OP_WREN: wel_q <= 1'b1;
                OP_WRDI: wel_q <= 1'b0;
                OP_RDSR: begin
                  phase_q  <= PH_DATA;
                  cmd_q    <= C_RDSR;
                  tx_act_q <= 1'b1;
                end
                OP_WRSR: if (wel_q) begin
                  phase_q <= PH_DATA;
                  cmd_q   <= C_WRSR;
                end
                OP_READ: begin
                  phase_q <= PH_ADDR;
                  cmd_q   <= C_RD;
                end
                OP_WRITE: if (wel_q) begin
                  phase_q <= PH_ADDR;
                  cmd_q   <= C_WR;
                end
                default: ;
              endcase
            end
          end
          PH_ADDR: begin
            abyte_q <= abyte_q + 1'b1;
            if (abyte_q == ABW'(ADDR_BYTES - 1)) begin
              phase_q <= PH_DATA;
              if (cmd_q == C_RD) fetch_q <= 1'b1;
            end
          end
          PH_DATA: begin
            if (cmd_q == C_RD) begin
              addr_q  <= addr_q + 1'b1;  // wraps at the top of the array
              fetch_q <= 1'b1;
            end else if ((cmd_q == C_WR || cmd_q == C_WRSR) && !pend_q) begin
              wdata_q <= rx_next;
              pend_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // output shift path
  logic stat_load, tx_load, tx_shift;
  logic [BYTE_W-1:0] tx_data;

  assign stat_load = byte_done &&
                     ((phase_q == PH_OP && rx_next == OP_RDSR) ||
                      (phase_q == PH_DATA && cmd_q == C_RDSR));
  assign tx_load   = !cs_fall && !cs_rise && (rd_vld_q || stat_load);
  assign tx_data   = rd_vld_q ? mem_rdata_i : stat_now;
  assign tx_shift  = sck_fall && tx_act_q && (bit_q != '0);

  spi_ee_txsh #(.W(BYTE_W)) u_txsh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tx_load),
    .data_i  (tx_data),
    .shift_i (tx_shift),
    .bit_o   (so_o)
  );

  spi_ee_wtimer #(.CYCLES(WR_CYCLES)) u_wtimer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (timer_busy)
  );

  assign so_oe_o      = cs_act & tx_act_q;
  assign mem_we_o     = commit && (cmd_q == C_WR);
  assign mem_req_o    = fetch_q | mem_we_o;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;
  assign stat_wr_o    = commit && (cmd_q == C_WRSR);
  assign stat_wdata_o = wdata_q;
  assign busy_o       = timer_busy;
endmodule

// File: rtl/spi_ee_front_chk.sv
module spi_ee_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic so_oe_o,
  input logic mem_req_o,
  input logic mem_we_o,
  input logic stat_wr_o,
  input logic busy_o
);
  // R4: an array write is one isolated strobe
  p_we_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R4: write qualifier only together with a strobe
  p_we_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  // R4/R7: a busy cycle only follows a committed write
  p_busy_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(mem_we_o || stat_wr_o));

  // R8: no commits while busy
  p_quiet_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!mem_we_o && !stat_wr_o));

  // R7: status and array writes never coincide
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && stat_wr_o));

  // R10: deselected for several cycles means output disabled
  p_oe_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !so_oe_o);
endmodule

bind spi_ee_front spi_ee_front_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .so_oe_o   (so_oe_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .stat_wr_o (stat_wr_o),
  .busy_o    (busy_o)
);

// File: tb/spi_ee_front_tb_top.sv
module spi_ee_front_tb_top;
  localparam int AW   = 10;
  localparam int HALF = 8;
  localparam int WRC  = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, mem_req, mem_we, stat_wr, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, stat_wdata, prot;

  always #5 clk = ~clk;

  spi_ee_front #(.AW(AW), .ADDR_FIELD_W(16), .WR_CYCLES(WRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .stat_wr_o(stat_wr), .stat_wdata_o(stat_wdata), .stat_i(prot), .busy_o(busy)
  );

  // memory array and protection unit models
  logic [7:0] ram [1024];
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0] pre_d = '0;
  int we_cnt = 0;
  int sw_cnt = 0;

  always @(posedge clk) begin
    if (pre_we) ram[pre_addr] <= pre_d;
    else if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
    if (mem_we) we_cnt <= we_cnt + 1;
    if (stat_wr) sw_cnt <= sw_cnt + 1;
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) prot <= 8'hA7;
    else if (stat_wr) prot <= stat_wdata;

  int n_run = 0, n_fail = 0;
  logic mode3 = 1'b0;
  logic oe_all, oe_any;
  logic [7:0] rbuf [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); pre_we = 1'b1; pre_addr = a; pre_d = d;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic cs_low();
    sck = mode3; clks(4);
    cs_n = 1'b0; clks(4);
    oe_all = 1'b1; oe_any = 1'b0;
  endtask

  task automatic cs_high();
    clks(4); cs_n = 1'b1; clks(8);
  endtask

  task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      if (mode3) sck = 1'b0;
      si = d[i];
      clks(HALF);
      r[i] = so;
      oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1;
      clks(HALF);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r);
    xbits(d, 8, r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_low(); xfer(op, r); cs_high();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    cs_low(); xfer(8'h05, r);
    oe_all = 1'b1; xfer(8'h00, s);
    cs_high();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_low(); xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
    oe_all = 1'b1;
    for (int i = 0; i < n; i++) begin xfer(8'h00, r); rbuf[i] = r; end
    cs_high();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] r;
    cs_low(); xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
    xfer(d0, r); xfer(d1, r); cs_high();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * WRC && busy; i++) @(negedge clk);
    clks(2);
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    chk("R1 so_oe", so_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 stat_wr", stat_wr, 0);
  endtask

  task automatic t_status();
    logic [7:0] s;
    logic [7:0] r;
    cs_low(); xfer(8'h05, r); oe_all = 1'b1;
    xfer(8'h00, s); chk("R6 status byte", s, 8'hA4);
    xfer(8'h00, s); chk("R6 status repeat", s, 8'hA4);
    chk("R10 oe during status", oe_all, 1);
    cs_high();
    chk("R10 oe after CS high", so_oe, 0);
    cmd1(8'h06); rdsr(s); chk("R5 latch set", s, 8'hA6);
    cmd1(8'h04); rdsr(s); chk("R5 latch clear", s, 8'hA4);
  endtask

  task automatic t_unknown();
    logic [7:0] s;
    logic [7:0] r;
    cs_low(); xfer(8'hAB, r); oe_any = 1'b0; xfer(8'h00, r); xfer(8'h00, r); cs_high();
    chk("R12 oe stays low", oe_any, 0);
    chk("R12 busy", busy, 0);
    rdsr(s); chk("R12 status unchanged", s, 8'hA4);
  endtask

  task automatic t_write_nowel();
    int w0 = we_cnt;
    preload(10'h123, 8'hC3);
    wr(16'h0123, 8'h11, 8'h22);
    chk("R4 no write without latch", we_cnt - w0, 0);
    chk("R4 no busy without latch", busy, 0);
    rd(16'h0123, 1); chk("R4 data kept", rbuf[0], 8'hC3);
  endtask

  task automatic t_write_busy();
    logic [7:0] s;
    int w0 = we_cnt;
    preload(10'h050, 8'h3C);
    cmd1(8'h06);
    wr(16'hFD23, 8'h5A, 8'h77);
    chk("R4 one write pulse", we_cnt - w0, 1);
    chk("R4 busy started", busy, 1);
    rdsr(s); chk("R8 status while busy", s, 8'hFF);
    cmd1(8'h06);
    wr(16'h0050, 8'h99, 8'h00);
    chk("R8 write ignored while busy", we_cnt - w0, 1);
    rd(16'h0050, 1);
    chk("R8 read ignored while busy", oe_any, 0);
    wait_idle();
    chk("R4 busy ends", busy, 0);
    rdsr(s); chk("R8 latch not set while busy", s, 8'hA4);
    rd(16'h0050, 1); chk("R8 data kept", rbuf[0], 8'h3C);
    rd(16'h0123, 1); chk("R2 upper addr ignored", rbuf[0], 8'h5A);
  endtask

  task automatic t_read_wrap();
    preload(10'h3FE, 8'h81);
    preload(10'h3FF, 8'h42);
    preload(10'h000, 8'h18);
    rd(16'h03FE, 3);
    chk("R3 first byte", rbuf[0], 8'h81);
    chk("R3 increment", rbuf[1], 8'h42);
    chk("R3 wrap to 0", rbuf[2], 8'h18);
    chk("R10 oe during read", oe_all, 1);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    int w0 = we_cnt;
    int s0 = sw_cnt;
    cmd1(8'h06);
    cs_low(); xfer(8'h02, r); xfer(8'h00, r); xfer(8'h40, r); xbits(8'hF0, 4, r);
    cs_high();
    chk("R9 no write", we_cnt - w0, 0);
    chk("R9 no busy", busy, 0);
    cs_low(); xfer(8'h01, r); xbits(8'h8F, 5, r); cs_high();
    chk("R9 no status write", sw_cnt - s0, 0);
    chk("R9 no busy after status abort", busy, 0);
    cmd1(8'h04);
  endtask

  task automatic t_wrsr();
    logic [7:0] s;
    logic [7:0] r;
    int s0 = sw_cnt;
    cmd1(8'h06);
    cs_low(); xfer(8'h01, r); xfer(8'h8F, r); xfer(8'h12, r); cs_high();
    chk("R7 one status write", sw_cnt - s0, 1);
    chk("R7 status data", prot, 8'h8F);
    chk("R7 busy", busy, 1);
    wait_idle();
    rdsr(s); chk("R7 latch cleared", s, 8'h8C);
  endtask

  task automatic t_mode3();
    logic [7:0] s;
    int w0 = we_cnt;
    mode3 = 1'b1; sck = 1'b1; clks(4);
    rdsr(s); chk("R11 mode3 status", s, 8'h8C);
    cmd1(8'h06);
    wr(16'h02A5, 8'hE7, 8'h00);
    chk("R11 mode3 write", we_cnt - w0, 1);
    wait_idle();
    rd(16'h02A5, 1); chk("R11 mode3 read", rbuf[0], 8'hE7);
    rd(16'h03FE, 3);
    chk("R11 mode3 wrap", rbuf[2], 8'h18);
    mode3 = 1'b0; sck = 1'b0; clks(4);
    rd(16'h02A5, 1); chk("R11 mode0 read back", rbuf[0], 8'hE7);
  endtask

  initial begin
    clks(3);
    t_reset();
    rst_n = 1'b1;
    clks(4);
    t_reset();
    t_status();
    t_unknown();
    t_write_nowel();
    t_write_busy();
    t_read_wrap();
    t_abort();
    t_wrsr();
    t_mode3();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule